// File: doc/BRIEF.md
# Receive FIFO Interrupt Request Logic

This block turns the fill state of a small receive FIFO into interrupt requests for a host processor. It watches the FIFO's not-empty and full flags and the arrival of new words from the serial shifter. It keeps a sticky overrun flag, which is set when a word arrives while the FIFO is already full. A 2-bit trigger-select field, written by the processor, chooses whether a data request fires when the FIFO is not empty or only when it is full. An overrun always raises its own request, and that request takes the place of the data request.

Requests come from a three-state machine. The states are `REQ_NONE`, `REQ_DATA` and `REQ_OVERRUN`. The state register is updated on every clock from the trigger-select field and the flags as they stood before that edge. As a result, a change to the field reaches the request outputs one cycle after the write.

The named transitions are:
- *idle-to-data*: a trigger is met and overrun is clear.
- *any-to-overrun*: a trigger mode is selected and overrun is set.
- *any-to-idle*: the field is off or reserved, or no trigger is met.
- *data-to-data* and *overrun-to-overrun*: the holding cases.

The processor reads a control/status word that holds the field and the three status bits. It writes the same word to change the field and to clear the overrun flag.

Top module: `rxirq_top`

## Requirements
- R1: After hardware reset (`rst_n` low), both request outputs are low, the trigger-select field is 00 and the overrun flag is clear.
- R2: With trigger-select 00, no request is raised for any flag state, and the not-empty and full flags can still be read in the status word.
- R3: With trigger-select 01, `rx_data_req` is high when the FIFO is not empty and the overrun flag is clear.
- R4: With trigger-select 11, `rx_data_req` is high only when the FIFO is full and the overrun flag is clear. Not-empty alone raises no request.
- R5: Trigger-select 10 is reserved and raises no request, even while the overrun flag is set.
- R6: A word that arrives (`rx_push`) while `fifo_full` is high sets the overrun flag and is dropped: `fifo_wr` stays low. A word that arrives while the FIFO is not full drives `fifo_wr` high in the same cycle.
- R7: With trigger-select 01 or 11 and the overrun flag set, `rx_ovr_req` is raised in place of `rx_data_req`. The two outputs are never high together.
- R8: A status-word write with bit 18 set clears the overrun flag. A write with bit 18 clear leaves it unchanged. A new overrun in the same cycle as a clearing write wins, and the flag stays set.
- R9: A write to the trigger-select field takes effect on the request outputs one cycle late. In the cycle after the write, the request still follows the old field value.
- R10: Software reset (`sw_rst` high at a clock edge) clears the trigger-select field and the overrun flag. This takes priority over a new overrun and over a write.
- R11: The status word carries the trigger-select field at bits 13:12, not-empty at bit 17, overrun at bit 18 and full at bit 19. All other bits read zero.
- R12: Requests are registered. A flag change seen at one clock edge shows on the outputs after that edge, and a set overrun flag raises its request one edge after the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| fifo_not_empty | input | 1 | Receive FIFO holds at least one word |
| fifo_full | input | 1 | Receive FIFO has no free slot |
| rx_push | input | 1 | Shifter offers a new received word this cycle |
| csr_we | input | 1 | Processor write strobe for the status word |
| csr_wdata | input | CSR_W | Write data for the status word |
| csr_rdata | output | CSR_W | Control/status word read value |
| fifo_wr | output | 1 | Store the offered word in the FIFO |
| rx_data_req | output | 1 | Receive-data interrupt request |
| rx_ovr_req | output | 1 | Receive-overrun interrupt request |

## Verification
Each result is due at its own time after the stimulus:
- `fifo_wr` and the flag bits of `csr_rdata` follow the inputs in the same cycle.
- The trigger-select field and the overrun bit of `csr_rdata` change after the edge that samples the write, the overrun or the software reset.
- The requests follow a flag change after one edge, but follow a change of the field or of the overrun flag after two edges.

The bench applies inputs, waits for the rising edge, advances a behavioural model that uses the pre-edge field and overrun values, and compares every output at the falling edge that follows. Directed checks around the disabling write confirm that the old request is still present one cycle after the write and gone a cycle later.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    // Trigger-select encodings
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_NE   = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_FULL = 2'b11
    } rx_mode_e;

    // Request state machine
    typedef enum logic [1:0] {
        REQ_NONE    = 2'b00,
        REQ_DATA    = 2'b01,
        REQ_OVERRUN = 2'b10
    } req_state_e;

    // Status word layout
    localparam int MODE_LSB  = 12;
    localparam int MODE_W    = 2;
    localparam int NE_BIT    = 17;
    localparam int OVR_BIT   = 18;
    localparam int FULL_BIT  = 19;
    localparam int MIN_CSR_W = FULL_BIT + 1;

endpackage

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_rst,
    input  logic     fifo_full,
    input  logic     rx_push,
    input  logic     wr_mode_en,
    input  rx_mode_e wr_mode,
    input  logic     wr_ovr_clr,
    output rx_mode_e mode_q,
    output logic     ovr_q
);

    logic ovr_event;
    assign ovr_event = rx_push & fifo_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else if (sw_rst) begin
            mode_q <= MODE_OFF;
        end else if (wr_mode_en) begin
            mode_q <= wr_mode;
        end
    end

    // Clear priority: software reset, then new overrun, then write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (sw_rst) begin
            ovr_q <= 1'b0;
        end else if (ovr_event) begin
            ovr_q <= 1'b1;
        end else if (wr_ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_full && !sw_rst) |=> ovr_q);

    // R10
    sw_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (mode_q == MODE_OFF) && !ovr_q);

endmodule

// File: rtl/rxirq_fsm.sv
module rxirq_fsm
    import rxirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rx_mode_e mode_q,
    input  logic     ovr_q,
    input  logic     fifo_not_empty,
    input  logic     fifo_full,
    output logic     rx_data_req,
    output logic     rx_ovr_req
);

    req_state_e state_q, state_d;

    // Next state from the pre-edge field and overrun flag
    always_comb begin
        state_d = REQ_NONE;
        unique case (mode_q)
            MODE_OFF:  state_d = REQ_NONE;
            MODE_RSVD: state_d = REQ_NONE;
            MODE_NE: begin
                if (ovr_q)               state_d = REQ_OVERRUN;
                else if (fifo_not_empty) state_d = REQ_DATA;
                else                     state_d = REQ_NONE;
            end
            MODE_FULL: begin
                if (ovr_q)          state_d = REQ_OVERRUN;
                else if (fifo_full) state_d = REQ_DATA;
                else                state_d = REQ_NONE;
            end
            default: state_d = REQ_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        rx_data_req = 1'b0;
        rx_ovr_req  = 1'b0;
        unique case (state_q)
            REQ_NONE:    ;
            REQ_DATA:    rx_data_req = 1'b1;
            REQ_OVERRUN: rx_ovr_req  = 1'b1;
            default:     ;
        endcase
    end

    // R7
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_data_req && rx_ovr_req));

    // R5
    rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RSVD) |=> !rx_data_req && !rx_ovr_req);

    // R2
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |=> !rx_data_req && !rx_ovr_req);

    // R7
    ovr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && (mode_q == MODE_NE || mode_q == MODE_FULL)) |=> rx_ovr_req);

endmodule

// File: rtl/rxirq_top.sv
module rxirq_top
    import rxirq_pkg::*;
#(
    parameter int CSR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             fifo_not_empty,
    input  logic             fifo_full,
    input  logic             rx_push,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             fifo_wr,
    output logic             rx_data_req,
    output logic             rx_ovr_req
);

    rx_mode_e mode_q;
    logic     ovr_q;
    logic     unused_wbits;

    assign unused_wbits = ^csr_wdata;

    // Offered word is stored only if there is room
    assign fifo_wr = rx_push & ~fifo_full;

    rxirq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .fifo_full  (fifo_full),
        .rx_push    (rx_push),
        .wr_mode_en (csr_we),
        .wr_mode    (rx_mode_e'(csr_wdata[MODE_LSB +: MODE_W])),
        .wr_ovr_clr (csr_we & csr_wdata[OVR_BIT]),
        .mode_q     (mode_q),
        .ovr_q      (ovr_q)
    );

    rxirq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_q         (mode_q),
        .ovr_q          (ovr_q),
        .fifo_not_empty (fifo_not_empty),
        .fifo_full      (fifo_full),
        .rx_data_req    (rx_data_req),
        .rx_ovr_req     (rx_ovr_req)
    );

    always_comb begin
        csr_rdata                         = '0;
        csr_rdata[MODE_LSB +: MODE_W]     = mode_q;
        csr_rdata[NE_BIT]                 = fifo_not_empty;
        csr_rdata[OVR_BIT]                = ovr_q;
        csr_rdata[FULL_BIT]               = fifo_full;
    end

    // R11
    width_ok_chk: assert final (CSR_W >= MIN_CSR_W);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !rx_data_req && !rx_ovr_req);

endmodule

// File: tb/sim_rxirq_top.sv
module sim_rxirq_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_rst = 1'b0;
    logic         ne = 1'b0;
    logic         full = 1'b0;
    logic         push = 1'b0;
    logic         we = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         fifo_wr, data_req, ovr_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int m_en = 0;
    bit m_ovr = 0;
    bit m_data = 0;
    bit m_oreq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxirq_top #(.CSR_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .fifo_not_empty(ne), .fifo_full(full), .rx_push(push),
        .csr_we(we), .csr_wdata(wdata), .csr_rdata(rdata),
        .fifo_wr(fifo_wr), .rx_data_req(data_req), .rx_ovr_req(ovr_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Advance model at the rising edge using pre-edge state
    task automatic model_edge();
        bit any, trig;
        if (!rst_n) begin
            m_en = 0; m_ovr = 0; m_data = 0; m_oreq = 0;
            return;
        end
        any  = (m_en == 1) || (m_en == 3);
        trig = (m_en == 1 && ne) || (m_en == 3 && full);
        m_oreq = any && m_ovr;
        m_data = !m_oreq && trig;
        if (sw_rst) begin
            m_en = 0; m_ovr = 0;
        end else begin
            if (we) m_en = int'(wdata[13:12]);
            if (push && full) m_ovr = 1;
            else if (we && wdata[18]) m_ovr = 0;
        end
    endtask

    function automatic logic [W-1:0] exp_word();
        logic [W-1:0] v = '0;
        v[13:12] = m_en[1:0];
        v[17] = ne;
        v[18] = m_ovr;
        v[19] = full;
        return v;
    endfunction

    // One cycle: inputs already set; edge, model, compare at falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "rx_data_req", int'(data_req), int'(m_data));
        chk(tag, "rx_ovr_req", int'(ovr_req), int'(m_oreq));
        chk(tag, "csr_rdata", int'(rdata), int'(exp_word()));
        chk(tag, "fifo_wr", int'(fifo_wr), int'(push && !full));
        we = 0; push = 0; sw_rst = 0;
    endtask

    task automatic wr(input int en, input bit clr, input string tag);
        wdata = '0;
        wdata[13:12] = en[1:0];
        wdata[18] = clr;
        we = 1;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        ne = 1; full = 1;
        repeat (2) tick("R1");
        chk("R1", "reset data_req", int'(data_req), 0);
        rst_n = 1;
        repeat (2) tick("R1");
        chk("R1", "field after reset", int'(rdata[13:12]), 0);

        // R2: disabled, flags readable
        ne = 1; full = 0; repeat (2) tick("R2");
        chk("R2", "ne bit 17", int'(rdata[17]), 1);
        ne = 1; full = 1; repeat (2) tick("R2");
        chk("R2", "full bit 19", int'(rdata[19]), 1);
        chk("R2", "no request", int'(data_req | ovr_req), 0);

        // R3: not-empty trigger
        ne = 0; full = 0; wr(1, 0, "R3");
        repeat (2) tick("R3");
        ne = 1; repeat (2) tick("R3");
        chk("R3", "data on ne", int'(data_req), 1);
        // R12: single-cycle flag change
        ne = 0; tick("R12");
        chk("R12", "drop after one edge", int'(data_req), 0);
        ne = 1; tick("R12");

        // R4: full trigger
        wr(3, 0, "R4");
        ne = 1; full = 0; repeat (2) tick("R4");
        chk("R4", "ne alone silent", int'(data_req), 0);
        full = 1; repeat (2) tick("R4");
        chk("R4", "data on full", int'(data_req), 1);

        // R6 / R7: overrun event
        push = 1; tick("R6");
        chk("R6", "dropped word", int'(fifo_wr), 0);
        tick("R7");
        chk("R7", "overrun request", int'(ovr_req), 1);
        chk("R7", "data suppressed", int'(data_req), 0);
        full = 0; push = 1; tick("R6");
        wr(1, 0, "R7"); repeat (2) tick("R7");

        // R8: write-one-to-clear
        wr(1, 0, "R8");
        chk("R8", "clear bit 0 keeps flag", int'(rdata[18]), 1);
        full = 1; push = 1; wr(1, 1, "R8");
        chk("R8", "set wins over clear", int'(rdata[18]), 1);
        full = 0; wr(1, 1, "R8");
        chk("R8", "flag cleared", int'(rdata[18]), 0);
        repeat (2) tick("R8");

        // R5: reserved mode with overrun
        full = 1; push = 1; tick("R5");
        wr(2, 0, "R5"); repeat (3) tick("R5");
        chk("R5", "reserved silent", int'(data_req | ovr_req), 0);
        wr(1, 1, "R5"); full = 0; repeat (2) tick("R5");

        // R9: delayed disable
        ne = 1; repeat (2) tick("R9");
        wr(0, 0, "R9");
        chk("R9", "request held one cycle", int'(data_req), 1);
        tick("R9");
        chk("R9", "request gone", int'(data_req), 0);

        // R10: software reset
        wr(3, 0, "R10"); full = 1; push = 1; tick("R10");
        sw_rst = 1; push = 1; we = 1; wdata = '0; wdata[13:12] = 2'b11; tick("R10");
        chk("R10", "field cleared", int'(rdata[13:12]), 0);
        chk("R10", "overrun cleared", int'(rdata[18]), 0);
        tick("R10");

        // R11 / mixed traffic
        for (int i = 0; i < 400; i++) begin
            ne = 1'($urandom); full = 1'($urandom); push = 1'($urandom);
            sw_rst = (($urandom % 23) == 0);
            we = (($urandom % 5) == 0);
            wdata = W'($urandom);
            tick("R11");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule